// File: doc/BRIEF.md
# Embedded Nonvolatile Word Program Controller

This block sits between a simple 32-bit read/write strobe bus and an on-chip nonvolatile word array. The bus reaches two regions, picked by a region-select input. The control region holds a handful of registers. The data window maps the array as 32-bit words on a 4-byte stride. The nonvolatile cells are modelled as ordinary flops. The erase/program cycle is modelled as a busy period counted in ticks of a divided program clock.

Software first sets the divider so that the program clock falls between 800 kHz and 1600 kHz, with about 1.5 MHz as the target. It then enables automatic programming and leaves power-down. Once the wake-up time has passed, each single word written into the data window starts one timed cycle. When the cycle ends, a sticky end-of-program flag sets, and software clears it by writing a one. The array is split into 128-byte pages. The topmost page holds initialisation data and cannot be written.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the auto-program register (byte offset 0x00C, bit 0) reads 0, the divider register (0x014) reads 0, the power-down register (0x018, bit 0, 1 means powered down) reads 1 and the status register (0xFE0) reads 0. `busy` and `irq` are low.
- R2: The divider register holds the division factor minus one and reads back as written. A program cycle keeps `busy` high for exactly PROG_TICKS*(divider+1) bus clock cycles, starting on the edge that captures the write.
- R3: Writing 0 to the power-down register while it holds 1 starts a wake-up period. During that period `busy` is high for exactly WAKE_TICKS*(divider+1) cycles. Data-window reads return 0 while the block is powered down or waking. Data-window writes in either state are ignored and set the error flag.
- R4: With auto-program on, an accepted word write raises `busy` on the capturing edge. The new word replaces the stored word only when the cycle ends. A read during the cycle returns the old word. Data-window reads return the addressed word one cycle after the read strobe.
- R5: Status bit 2 sets when a program cycle ends and stays set until a write to the clear register (0xFE8) has bit 2 at 1. A write with bit 2 at 0 leaves it set. `irq` follows status bit 2.
- R6: A data-window write while a program cycle runs is ignored. It sets the error flag (status bit 0), which stays set until a write to the clear register has bit 0 at 1.
- R7: Writes to the topmost page, to word indexes at or beyond the array size, or to byte addresses with bits [1:0] not zero are ignored. They start no cycle and set the error flag.
- R8: With auto-program off, a data-window write starts no cycle, changes no word and sets the error flag.
- R9: A power-down register write during a program cycle is ignored. The cycle completes, the register still reads 0, and the error flag sets.
- R10: Reset leaves the array contents untouched. After a new wake-up the stored words read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, data appears on `rdata` one cycle later |
| win_sel | input | 1 | 1 selects the data window, 0 the control region |
| addr | input | ADDR_W | Byte address inside the selected region |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| busy | output | 1 | High during wake-up and during a program cycle |
| irq | output | 1 | Level interrupt, equal to the end-of-program status bit |

## Verification
The bench builds the block with a 64-word array (two pages, so the second page is the protected one), a 4-bit divider, a program time of 3 ticks and a wake time of 2 ticks. With these values a full cycle lasts at most a dozen bus cycles. That makes it cheap to sweep every divider value from 0 to 3 and compare each measured busy length with the product formula. Every writable word can be programmed with its own pattern and read back, the protected page and out-of-range index sit only a few words away, and a second write can be landed inside a running cycle.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

   // Byte offsets inside the control region
   localparam int OFF_AUTO   = 'h00C;
   localparam int OFF_DIV    = 'h014;
   localparam int OFF_PWR    = 'h018;
   localparam int OFF_STAT   = 'hFE0;
   localparam int OFF_CLR    = 'hFE8;

   // Status bit positions
   localparam int STAT_ERR   = 0;
   localparam int STAT_DONE  = 2;

   localparam int BUS_W      = 32;
   localparam int WORD_BYTES = BUS_W / 8;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_WAKE = 2'd1,
      ST_IDLE = 2'd2,
      ST_PROG = 2'd3
   } nvm_state_e;

endpackage

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   generate
      if (DIV_W < 1 || DIV_W > 31) begin : g_bad_width
         $error("nvm_tick_gen: DIV_W must be within 1..31");
      end
   endgenerate

   assign wrap = (cnt_q == div);
   assign tick = en && !restart && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !en || wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/nvm_tick_timer.sv
module nvm_tick_timer #(
   parameter int TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic done
);

   localparam int CW = $clog2(TICKS + 1);

   logic [CW-1:0] cnt_q;

   generate
      if (TICKS < 1) begin : g_bad_ticks
         $error("nvm_tick_timer: TICKS must be at least 1");
      end
   endgenerate

   assign done = tick && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(TICKS);
      end else if (tick && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/nvm_word_array.sv
module nvm_word_array #(
   parameter int WORDS  = 256,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] widx,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(WORDS)-1:0] ridx,
   output logic [DATA_W-1:0]        rdata
);

   localparam int AW = $clog2(WORDS);

   logic [DATA_W-1:0] cells [WORDS];

   generate
      if (WORDS < 2 || (1 << AW) != WORDS) begin : g_bad_words
         $error("nvm_word_array: WORDS must be a power of two, at least 2");
      end
      // One storage row per word; rows carry no reset so contents survive it
      for (genvar gi = 0; gi < WORDS; gi++) begin : g_row
         always_ff @(posedge clk) begin
            if (we && widx == AW'(gi)) begin
               cells[gi] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = cells[ridx];

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
   import nvm_prog_pkg::*;
#(
   parameter int WORDS      = 256,
   parameter int PAGE_BYTES = 128,
   parameter int ADDR_W     = 12,
   parameter int DIV_W      = 8,
   parameter int PROG_TICKS = 4500,
   parameter int WAKE_TICKS = 150
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              win_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              busy,
   output logic              irq
);

   localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES;
   localparam int WRITABLE   = WORDS - PAGE_WORDS;
   localparam int IDX_W      = ADDR_W - 2;
   localparam int AW         = $clog2(WORDS);
   localparam logic [IDX_W:0] WORDS_L    = (IDX_W + 1)'(WORDS);
   localparam logic [IDX_W:0] WRITABLE_L = (IDX_W + 1)'(WRITABLE);

   generate
      if (PAGE_BYTES % WORD_BYTES != 0 || PAGE_WORDS < 1) begin : g_bad_page
         $error("nvm_prog_ctrl: PAGE_BYTES must be a positive multiple of 4");
      end
      if (WORDS < 2 * PAGE_WORDS) begin : g_bad_size
         $error("nvm_prog_ctrl: array must hold at least two pages");
      end
      if (ADDR_W < 12 || WORDS > (1 << IDX_W)) begin : g_bad_addr
         $error("nvm_prog_ctrl: ADDR_W too small for registers or array");
      end
   endgenerate

   // ---------------------------------------------------------------
   // Access decode
   // ---------------------------------------------------------------
   nvm_state_e        state_q;
   logic              auto_q;
   logic [DIV_W-1:0]  div_q;
   logic              pwr_q;
   logic              done_q;
   logic              err_q;
   logic [AW-1:0]     pend_idx_q;
   logic [31:0]       pend_data_q;
   logic [31:0]       rdata_q;

   logic              reg_wr, win_wr;
   logic [IDX_W-1:0]  idx;
   logic              aligned, in_range, writable, readable;
   logic              accept, reject;
   logic              pwr_wr, clr_wr, wake_start, sleep_req, pwr_blocked;
   logic              tick, wake_done, prog_done, tick_en;
   logic              prog_act;
   logic [31:0]       arr_rd, reg_rd, win_rd;

   assign reg_wr   = wr_en && !win_sel;
   assign win_wr   = wr_en &&  win_sel;
   assign idx      = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = ({1'b0, idx} < WORDS_L);
   assign writable = ({1'b0, idx} < WRITABLE_L);
   assign readable = (state_q == ST_IDLE) || (state_q == ST_PROG);

   assign accept = win_wr && (state_q == ST_IDLE) && auto_q && aligned && writable;
   assign reject = win_wr && !accept;

   assign pwr_wr      = reg_wr && (addr == ADDR_W'(OFF_PWR));
   assign clr_wr      = reg_wr && (addr == ADDR_W'(OFF_CLR));
   assign pwr_blocked = pwr_wr && (state_q == ST_PROG);
   assign wake_start  = pwr_wr && !wdata[0] && (state_q == ST_OFF);
   assign sleep_req   = pwr_wr &&  wdata[0] &&
                        ((state_q == ST_WAKE) || (state_q == ST_IDLE));

   assign tick_en  = (state_q == ST_WAKE) || (state_q == ST_PROG);
   assign prog_act = (state_q == ST_PROG);

   // ---------------------------------------------------------------
   // Program clock and the two timed periods
   // ---------------------------------------------------------------
   nvm_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (tick_en),
      .restart (wake_start || accept),
      .div     (div_q),
      .tick    (tick)
   );

   nvm_tick_timer #(.TICKS(WAKE_TICKS)) u_wake_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wake_start),
      .tick  (tick && (state_q == ST_WAKE)),
      .done  (wake_done)
   );

   nvm_tick_timer #(.TICKS(PROG_TICKS)) u_prog_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .tick  (tick && prog_act),
      .done  (prog_done)
   );

   // ---------------------------------------------------------------
   // Storage
   // ---------------------------------------------------------------
   nvm_word_array #(.WORDS(WORDS), .DATA_W(32)) u_array (
      .clk   (clk),
      .we    (prog_done),
      .widx  (pend_idx_q),
      .wdata (pend_data_q),
      .ridx  (idx[AW-1:0]),
      .rdata (arr_rd)
   );

   // ---------------------------------------------------------------
   // Control state
   // ---------------------------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_OFF;
         auto_q      <= 1'b0;
         div_q       <= '0;
         pwr_q       <= 1'b1;
         pend_idx_q  <= '0;
         pend_data_q <= '0;
      end else begin
         if (reg_wr && addr == ADDR_W'(OFF_AUTO)) begin
            auto_q <= wdata[0];
         end
         if (reg_wr && addr == ADDR_W'(OFF_DIV)) begin
            div_q <= wdata[DIV_W-1:0];
         end
         unique case (state_q)
            ST_OFF: begin
               if (wake_start) begin
                  state_q <= ST_WAKE;
                  pwr_q   <= 1'b0;
               end
            end
            ST_WAKE: begin
               if (sleep_req) begin
                  state_q <= ST_OFF;
                  pwr_q   <= 1'b1;
               end else if (wake_done) begin
                  state_q <= ST_IDLE;
               end
            end
            ST_IDLE: begin
               if (sleep_req) begin
                  state_q <= ST_OFF;
                  pwr_q   <= 1'b1;
               end else if (accept) begin
                  state_q     <= ST_PROG;
                  pend_idx_q  <= idx[AW-1:0];
                  pend_data_q <= wdata;
               end
            end
            ST_PROG: begin
               if (prog_done) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_OFF;
         endcase
      end
   end

   // Sticky status flags: a setting event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (prog_done) begin
            done_q <= 1'b1;
         end else if (clr_wr && wdata[STAT_DONE]) begin
            done_q <= 1'b0;
         end
         if (reject || pwr_blocked) begin
            err_q <= 1'b1;
         end else if (clr_wr && wdata[STAT_ERR]) begin
            err_q <= 1'b0;
         end
      end
   end

   // ---------------------------------------------------------------
   // Read path
   // ---------------------------------------------------------------
   always_comb begin
      reg_rd = '0;
      if (addr == ADDR_W'(OFF_AUTO)) begin
         reg_rd[0] = auto_q;
      end else if (addr == ADDR_W'(OFF_DIV)) begin
         reg_rd = 32'(div_q);
      end else if (addr == ADDR_W'(OFF_PWR)) begin
         reg_rd[0] = pwr_q;
      end else if (addr == ADDR_W'(OFF_STAT)) begin
         reg_rd[STAT_DONE] = done_q;
         reg_rd[STAT_ERR]  = err_q;
      end
   end

   assign win_rd = (readable && aligned && in_range) ? arr_rd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= win_sel ? win_rd : reg_rd;
      end
   end

   assign rdata = rdata_q;
   assign busy  = tick_en;
   assign irq   = done_q;

endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              win_sel,
   input logic [ADDR_W-1:0] addr,
   input logic              clr_done_bit,
   input logic              busy,
   input logic              irq,
   input logic              prog_act,
   input logic              err_flag,
   input logic              pwr_flag
);

   logic clr_done_wr;
   assign clr_done_wr = wr_en && !win_sel && (addr == ADDR_W'('hFE8)) && clr_done_bit;

   AST_PROG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_act) |-> $past(wr_en && win_sel)); // R4

   AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_act) |-> irq); // R5

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_done_wr) |=> irq); // R5

   AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_act && wr_en && win_sel) |=> err_flag); // R6

   AST_AWAKE_WHILE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      prog_act |-> (!pwr_flag && busy)); // R9

endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .win_sel      (win_sel),
   .addr         (addr),
   .clr_done_bit (wdata[2]),
   .busy         (busy),
   .irq          (irq),
   .prog_act     (prog_act),
   .err_flag     (err_q),
   .pwr_flag     (pwr_q)
);

// File: tb/test_nvm_prog_ctrl.sv
module test_nvm_prog_ctrl;

   localparam int WORDS = 64;
   localparam int PAGE  = 128;
   localparam int AW    = 12;
   localparam int DW    = 4;
   localparam int PT    = 3;
   localparam int WT    = 2;
   localparam int WRITABLE = WORDS - PAGE / 4;

   localparam logic [AW-1:0] A_AUTO = 12'h00C;
   localparam logic [AW-1:0] A_DIV  = 12'h014;
   localparam logic [AW-1:0] A_PWR  = 12'h018;
   localparam logic [AW-1:0] A_STAT = 12'hFE0;
   localparam logic [AW-1:0] A_CLR  = 12'hFE8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic          win_sel = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          busy, irq;

   int checks = 0;
   int failures = 0;
   logic [31:0] model [WORDS];

   always #2 clk = ~clk;

   nvm_prog_ctrl #(
      .WORDS(WORDS), .PAGE_BYTES(PAGE), .ADDR_W(AW), .DIV_W(DW),
      .PROG_TICKS(PT), .WAKE_TICKS(WT)
   ) i_nvm_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .win_sel(win_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
      .busy(busy), .irq(irq)
   );

   function automatic logic [31:0] pat(input int i);
      return 32'hC3A5_0000 + 32'(i) * 32'h0001_0203;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic bus_wr(input logic win, input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; win_sel = win; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic win, input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; win_sel = win; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   // Counts negedges with busy high, starting at the current negedge
   task automatic busy_len(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v, old0, old1;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 busy", 32'(busy), 0);
      check("R1 irq", 32'(irq), 0);
      bus_rd(0, A_AUTO, v); check("R1 auto", v, 0);
      bus_rd(0, A_DIV, v);  check("R1 div", v, 0);
      bus_rd(0, A_PWR, v);  check("R1 pwr", v, 1);
      bus_rd(0, A_STAT, v); check("R1 status", v, 0);

      // R3 write while powered down is ignored and flags an error
      bus_wr(1, 12'h000, 32'hDEAD0000);
      check("R3 no busy when down", 32'(busy), 0);
      bus_rd(0, A_STAT, v); check("R3 err when down", v, 32'h1);
      bus_wr(0, A_CLR, 32'h1);
      bus_rd(0, A_STAT, v); check("R6 err cleared", v, 0);

      bus_wr(0, A_AUTO, 32'h1);

      // R2/R3/R5 sweep of divider values
      for (int d = 0; d < 4; d++) begin
         bus_wr(0, A_DIV, 32'(d));
         bus_rd(0, A_DIV, v); check("R2 div readback", v, 32'(d));
         bus_wr(0, A_PWR, 32'h1);
         bus_wr(0, A_PWR, 32'h0);
         busy_len(n); check("R3 wake length", 32'(n), 32'(WT * (d + 1)));
         bus_rd(0, A_PWR, v); check("R3 pwr awake", v, 0);
         bus_wr(1, 12'(d * 4), 32'h1000 + 32'(d));
         busy_len(n); check("R2 program length", 32'(n), 32'(PT * (d + 1)));
         model[d] = 32'h1000 + 32'(d);
         check("R5 irq set", 32'(irq), 1);
         bus_rd(0, A_STAT, v); check("R5 status done", v, 32'h4);
         bus_wr(0, A_CLR, 32'h0);
         check("R5 clear with zero", 32'(irq), 1);
         bus_wr(0, A_CLR, 32'h4);
         check("R5 cleared", 32'(irq), 0);
      end

      // R3 reads and writes during wake-up (divider 3 => 8 cycles)
      bus_wr(0, A_PWR, 32'h1);
      bus_rd(1, 12'h000, v); check("R3 read while down", v, 0);
      bus_wr(0, A_PWR, 32'h0);
      bus_rd(1, 12'h000, v); check("R3 read while waking", v, 0);
      bus_wr(1, 12'h004, 32'h5555AAAA);
      bus_rd(0, A_STAT, v); check("R3 err while waking", v, 32'h1);
      busy_len(n);
      bus_rd(1, 12'h004, v); check("R3 word untouched", v, model[1]);
      bus_wr(0, A_CLR, 32'h1);

      // R4 program every writable word, then read all back
      bus_wr(0, A_DIV, 32'h0);
      for (int i = 0; i < WRITABLE; i++) begin
         bus_wr(1, 12'(i * 4), pat(i));
         busy_len(n);
         model[i] = pat(i);
      end
      for (int i = 0; i < WRITABLE; i++) begin
         bus_rd(1, 12'(i * 4), v); check("R4 sweep readback", v, model[i]);
      end
      bus_wr(0, A_CLR, 32'h4);

      // R7 protected page, out-of-range and misaligned writes
      bus_rd(1, 12'(WRITABLE * 4), old0);
      bus_rd(1, 12'((WORDS - 1) * 4), old1);
      bus_wr(1, 12'(WRITABLE * 4), 32'h11111111);
      check("R7 no busy on last page", 32'(busy), 0);
      bus_wr(1, 12'((WORDS - 1) * 4), 32'h22222222);
      bus_rd(1, 12'(WRITABLE * 4), v); check("R7 last page first word", v, old0);
      bus_rd(1, 12'((WORDS - 1) * 4), v); check("R7 last page last word", v, old1);
      bus_rd(0, A_STAT, v); check("R7 err", v, 32'h1);
      bus_wr(0, A_CLR, 32'h1);
      bus_wr(1, 12'(5 * 4 + 2), 32'h33333333);
      check("R7 no busy misaligned", 32'(busy), 0);
      bus_rd(1, 12'(5 * 4), v); check("R7 misaligned untouched", v, model[5]);
      bus_wr(1, 12'(WORDS * 4), 32'h44444444);
      bus_rd(1, 12'(WORDS * 4), v); check("R7 out of range reads 0", v, 0);
      bus_rd(0, A_STAT, v); check("R7 err again", v, 32'h1);
      bus_wr(0, A_CLR, 32'h1);

      // R6 write during a cycle, R4 read during a cycle (divider 3 => 12 cycles)
      bus_wr(0, A_DIV, 32'h3);
      bus_wr(1, 12'h000, 32'hAAAA0001);
      bus_wr(1, 12'h008, 32'hBBBB0002);
      bus_rd(1, 12'h000, v); check("R4 old word during cycle", v, model[0]);
      bus_rd(0, A_STAT, v); check("R6 err during cycle", v, 32'h1);
      busy_len(n);
      model[0] = 32'hAAAA0001;
      bus_rd(1, 12'h000, v); check("R4 new word after cycle", v, model[0]);
      bus_rd(1, 12'h008, v); check("R6 second word untouched", v, model[2]);
      bus_wr(0, A_CLR, 32'h5);

      // R8 auto-program off
      bus_wr(0, A_AUTO, 32'h0);
      bus_wr(1, 12'h00C, 32'h66666666);
      check("R8 no busy", 32'(busy), 0);
      bus_rd(1, 12'h00C, v); check("R8 word untouched", v, model[3]);
      bus_rd(0, A_STAT, v); check("R8 err", v, 32'h1);
      bus_wr(0, A_CLR, 32'h1);
      bus_wr(0, A_AUTO, 32'h1);

      // R9 power-down write inside a cycle
      bus_wr(1, 12'h010, 32'h77770004);
      bus_wr(0, A_PWR, 32'h1);
      check("R9 still busy", 32'(busy), 1);
      busy_len(n);
      model[4] = 32'h77770004;
      bus_rd(0, A_PWR, v); check("R9 pwr unchanged", v, 0);
      bus_rd(0, A_STAT, v); check("R9 err and done", v, 32'h5);
      bus_rd(1, 12'h010, v); check("R9 cycle completed", v, model[4]);

      // R10 reset keeps array contents
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq after reset", 32'(irq), 0);
      bus_rd(0, A_PWR, v); check("R10 powered down", v, 1);
      bus_rd(0, A_DIV, v); check("R10 divider reset", v, 0);
      bus_wr(0, A_PWR, 32'h0);
      busy_len(n); check("R3 wake after reset", 32'(n), 32'(WT));
      for (int i = 0; i < 8; i++) begin
         bus_rd(1, 12'(i * 4), v); check("R10 preserved", v, model[i]);
      end

      finish_run();
   end

endmodule